// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Generator

This block holds the receive and transmit FIFOs of a UART-style peripheral and derives from their occupancy the flag bits and raw interrupt bits that software reads. The line side pushes received characters into the receive FIFO and pops characters out of the transmit FIFO. The register side does the reverse: it pops received characters and pushes characters to send. Baud timing and serial shifting live elsewhere. Both FIFOs present their oldest entry on a combinational output.

Interrupts use a trigger level of half the FIFO depth. The receive interrupt is raised by a push that lifts occupancy to at least half, and it is dropped by a pop that leaves occupancy below half. The transmit interrupt is re-evaluated on every transmit push or accepted pop, and it is high while occupancy is at most half. No character timing is modelled, so the receive-timeout interrupt rises on any receive push. It falls when a pop empties the FIFO or when software writes the clear strobe. The busy flag marks a completely full transmit FIFO. It does not mark a character in flight.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset both FIFOs are empty, `rx_empty` and `tx_empty` are 1, and `rx_full`, `tx_full`, `tx_busy`, all of `irq_raw`, all of `irq_masked` and `irq` are 0.
- R2: The receive FIFO returns characters in arrival order on `rx_data_out`. `rx_full` becomes 1 when a push brings occupancy to DEPTH. A push into a full receive FIFO is discarded.
- R3: A receive push clears `rx_empty` and sets the timeout bit `irq_raw[2]`. A receive pop that leaves occupancy at zero sets `rx_empty` and clears `irq_raw[2]`.
- R4: The receive interrupt `irq_raw[0]` is set by a push after which occupancy is at least DEPTH/2. It is cleared by a pop after which occupancy is below DEPTH/2.
- R5: Every receive pop clears `rx_full`. A pop on an empty receive FIFO changes nothing else.
- R6: A transmit push clears `tx_empty`. A push that fills the transmit FIFO sets `tx_full` and `tx_busy`. A push into a full transmit FIFO is discarded. Characters leave on `tx_data_out` in push order.
- R7: On every transmit push and every accepted transmit pop, `irq_raw[1]` takes the value (occupancy after the operation <= DEPTH/2). It stays 0 after reset until the first such event.
- R8: An accepted transmit pop clears `tx_full` and `tx_busy`. A pop that leaves the transmit FIFO empty sets `tx_empty`. A transmit pop on an empty FIFO is ignored.
- R9: A 1 on `rt_clear` clears `irq_raw[2]`. A receive push in the same cycle, or in any later cycle, raises it again.
- R10: `irq_masked` equals `irq_raw & irq_mask`, and `irq` is the OR of the three masked bits. Bit 0 is receive, bit 1 is transmit and bit 2 is receive timeout.
- R11: A receive push and a receive pop in the same cycle on a FIFO that is neither empty nor full leave occupancy unchanged and preserve order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | Line side writes a received character |
| rx_data_in | input | DW | Received character |
| rx_pop | input | 1 | Register read consumes the oldest received character |
| rx_data_out | output | DW | Oldest received character |
| tx_push | input | 1 | Register write queues a character to send |
| tx_data_in | input | DW | Character to send |
| tx_pop | input | 1 | Line side takes the oldest queued character |
| tx_data_out | output | DW | Oldest queued character |
| rt_clear | input | 1 | Write-one-to-clear strobe for the timeout interrupt |
| irq_mask | input | 3 | Interrupt enables {timeout, tx, rx} |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_busy | output | 1 | Transmit FIFO completely full |
| irq_raw | output | 3 | Raw interrupts {timeout, tx, rx} |
| irq_masked | output | 3 | Raw interrupts gated by the mask |
| irq | output | 1 | OR of the masked interrupts |

## Verification
The bench walks the transmit FIFO across the half-depth boundary at 16 and 17 entries and into the full state. It checks that pushes into a full FIFO are discarded, including a push and pop in the same cycle. A design with an off-by-one threshold, or one that lets the dropped character into storage, shows a wrong interrupt or a wrong character at `tx_data_out`. It also checks that the transmit interrupt stays low after reset and after a pop on an empty FIFO. A design that derives that bit from occupancy alone would raise it early. On the receive side, the bench checks the timeout bit through software clears and a clear that coincides with a push. It also checks that the receive interrupt persists down to exactly half, so a design that clears at the wrong level or lets the clear win the tie is caught.

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data_in,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_data_out,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_data_in,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_data_out,
  input  logic          rt_clear,
  input  logic [2:0]    irq_mask,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          tx_busy,
  output logic [2:0]    irq_raw,
  output logic [2:0]    irq_masked,
  output logic          irq
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [CW-1:0] RXT_C  = CW'(DEPTH - DEPTH / 2);

  logic [DW-1:0] rx_mem [DEPTH];
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_empty_q, rx_full_q, tx_empty_q, tx_full_q;
  logic          rx_irq_q, tx_irq_q, rt_irq_q;

  wire rx_wr = rx_push && (rx_cnt != FULL_C);
  wire rx_rd = rx_pop  && (rx_cnt != '0);
  wire tx_wr = tx_push && (tx_cnt != FULL_C);
  wire tx_rd = tx_pop  && (tx_cnt != '0);

  wire [CW-1:0] rx_cnt_nx = rx_cnt + CW'(rx_wr) - CW'(rx_rd);
  wire [CW-1:0] tx_cnt_nx = tx_cnt + CW'(tx_wr) - CW'(tx_rd);

  always_ff @(posedge clk) begin
    if (rx_wr) rx_mem[rx_wp] <= rx_data_in;
    if (tx_wr) tx_mem[tx_wp] <= tx_data_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (rx_wr) rx_wp <= rx_wp + AW'(1);
      if (rx_rd) rx_rp <= rx_rp + AW'(1);
      if (tx_wr) tx_wp <= tx_wp + AW'(1);
      if (tx_rd) tx_rp <= tx_rp + AW'(1);
      rx_cnt <= rx_cnt_nx;
      tx_cnt <= tx_cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      rx_irq_q   <= 1'b0;
      rt_irq_q   <= 1'b0;
    end else begin
      if (rx_wr)                           rx_empty_q <= 1'b0;
      else if (rx_rd && rx_cnt_nx == '0)   rx_empty_q <= 1'b1;

      if (rx_pop)                          rx_full_q <= 1'b0;
      else if (rx_wr && rx_cnt_nx == FULL_C) rx_full_q <= 1'b1;

      if (rx_push && rx_cnt_nx >= RXT_C)   rx_irq_q <= 1'b1;
      else if (rx_rd && rx_cnt_nx < RXT_C) rx_irq_q <= 1'b0;

      if (rx_push)                         rt_irq_q <= 1'b1;
      else if (rt_clear || (rx_rd && rx_cnt_nx == '0)) rt_irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_empty_q <= 1'b1;
      tx_full_q  <= 1'b0;
      tx_irq_q   <= 1'b0;
    end else begin
      if (tx_wr)                           tx_empty_q <= 1'b0;
      else if (tx_rd && tx_cnt_nx == '0)   tx_empty_q <= 1'b1;

      if (tx_wr && tx_cnt_nx == FULL_C)    tx_full_q <= 1'b1;
      else if (tx_rd)                      tx_full_q <= 1'b0;

      if (tx_push || tx_rd)                tx_irq_q <= (tx_cnt_nx <= HALF_C);
    end
  end

  assign rx_data_out = rx_mem[rx_rp];
  assign tx_data_out = tx_mem[tx_rp];
  assign rx_empty    = rx_empty_q;
  assign rx_full     = rx_full_q;
  assign tx_empty    = tx_empty_q;
  assign tx_full     = tx_full_q;
  assign tx_busy     = tx_full_q;
  assign irq_raw     = {rt_irq_q, tx_irq_q, rx_irq_q};
  assign irq_masked  = irq_raw & irq_mask;
  assign irq         = |irq_masked;

endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_push,
  input logic       rx_pop,
  input logic       tx_push,
  input logic       tx_pop,
  input logic       rt_clear,
  input logic [2:0] irq_mask,
  input logic       rx_empty,
  input logic       rx_full,
  input logic       tx_empty,
  input logic       tx_full,
  input logic       tx_busy,
  input logic [2:0] irq_raw,
  input logic       irq
);

  p_rx_full_not_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_empty);

  p_empty_no_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !irq_raw[2]);

  p_pop_clears_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !rx_full);

  p_tx_drop_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !tx_pop) |=> (tx_full && tx_busy && !tx_empty));

  p_tx_irq_low_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !irq_raw[1]);

  p_tx_empty_pop_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && tx_pop && !tx_push) |=> (tx_empty && $stable(irq_raw[1])));

  p_rt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_clear && !rx_push) |=> !irq_raw[2]);

  p_rt_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> irq_raw[2]);

  p_mask_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 3'b000) |-> !irq);

endmodule

bind uart_fifo_irq uart_fifo_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_push  (rx_push),
  .rx_pop   (rx_pop),
  .tx_push  (tx_push),
  .tx_pop   (tx_pop),
  .rt_clear (rt_clear),
  .irq_mask (irq_mask),
  .rx_empty (rx_empty),
  .rx_full  (rx_full),
  .tx_empty (tx_empty),
  .tx_full  (tx_full),
  .tx_busy  (tx_busy),
  .irq_raw  (irq_raw),
  .irq      (irq)
);

// File: tb/test_uart_fifo_irq.sv
`timescale 1ns/100ps
module test_uart_fifo_irq;
  localparam int D = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, rt_clear = 0;
  logic [7:0] rx_data_in = 0, tx_data_in = 0;
  logic [7:0] rx_data_out, tx_data_out;
  logic [2:0] irq_mask = 0;
  logic       rx_empty, rx_full, tx_empty, tx_full, tx_busy, irq;
  logic [2:0] irq_raw, irq_masked;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [7:0] txd = 8'h10;

  always #2.5 clk = ~clk;

  uart_fifo_irq #(.DEPTH(D), .DW(8)) i_uart_fifo_irq (
    .clk(clk), .rst_n(rst_n),
    .rx_push(rx_push), .rx_data_in(rx_data_in), .rx_pop(rx_pop), .rx_data_out(rx_data_out),
    .tx_push(tx_push), .tx_data_in(tx_data_in), .tx_pop(tx_pop), .tx_data_out(tx_data_out),
    .rt_clear(rt_clear), .irq_mask(irq_mask),
    .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty), .tx_full(tx_full),
    .tx_busy(tx_busy), .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq)
  );

  // {push, pop, reps[5:0], expected {tx_empty, tx_full, tx_busy, irq_raw[1]}}
  localparam logic [11:0] TBL [11] = '{
    {1'b0, 1'b1, 6'd1,  4'b1000},
    {1'b1, 1'b0, 6'd1,  4'b0001},
    {1'b1, 1'b0, 6'd15, 4'b0001},
    {1'b1, 1'b0, 6'd1,  4'b0000},
    {1'b1, 1'b0, 6'd15, 4'b0110},
    {1'b1, 1'b0, 6'd1,  4'b0110},
    {1'b1, 1'b1, 6'd1,  4'b0000},
    {1'b1, 1'b0, 6'd1,  4'b0110},
    {1'b0, 1'b1, 6'd16, 4'b0001},
    {1'b1, 1'b1, 6'd1,  4'b0001},
    {1'b0, 1'b1, 6'd16, 4'b1001}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input bit rp, input logic [7:0] rd, input bit rc, input bit tp,
                    input logic [7:0] td, input bit tc, input bit clr);
    bit racc, rdeq, tacc, tdeq;
    if (rc && rxq.size() > 0) chk("R2 rx order", rx_data_out, rxq[0]);
    if (tc && txq.size() > 0) chk("R6 tx order", tx_data_out, txq[0]);
    racc = rp && rxq.size() < D;
    rdeq = rc && rxq.size() > 0;
    tacc = tp && txq.size() < D;
    tdeq = tc && txq.size() > 0;
    rx_push = rp; rx_data_in = rd; rx_pop = rc;
    tx_push = tp; tx_data_in = td; tx_pop = tc; rt_clear = clr;
    @(posedge clk);
    #1;
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; rt_clear = 0;
    if (rdeq) void'(rxq.pop_front());
    if (racc) rxq.push_back(rd);
    if (tdeq) void'(txq.pop_front());
    if (tacc) txq.push_back(td);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 flags", {rx_full, tx_full, tx_busy}, 0);
    chk("R1 irq_raw", irq_raw, 0);
    chk("R1 irq", {irq_masked, irq}, 0);

    // Transmit table: R6, R7, R8
    foreach (TBL[i]) begin
      for (int k = 0; k < int'(TBL[i][9:4]); k++) begin
        op(0, 0, 0, TBL[i][11], txd, TBL[i][10], 0);
        txd = txd + 8'd1;
      end
      chk($sformatf("R8 tx_empty row %0d", i), tx_empty, TBL[i][3]);
      chk($sformatf("R6 tx_full row %0d", i), tx_full, TBL[i][2]);
      chk($sformatf("R6 tx_busy row %0d", i), tx_busy, TBL[i][1]);
      chk($sformatf("R7 tx irq row %0d", i), irq_raw[1], TBL[i][0]);
    end

    // Receive fill: R3, R4, R2
    op(1, 8'h41, 0, 0, 0, 0, 0);
    chk("R3 rx_empty cleared", rx_empty, 0);
    chk("R3 timeout raised", irq_raw[2], 1);
    chk("R4 rx irq low at 1", irq_raw[0], 0);
    for (int i = 2; i <= 15; i++) op(1, 8'h40 + 8'(i), 0, 0, 0, 0, 0);
    chk("R4 rx irq low at 15", irq_raw[0], 0);
    op(1, 8'h50, 0, 0, 0, 0, 0);
    chk("R4 rx irq high at 16", irq_raw[0], 1);
    for (int i = 17; i <= 32; i++) begin
      op(1, 8'h40 + 8'(i), 0, 0, 0, 0, 0);
      if (i == 31) chk("R2 not full at 31", rx_full, 0);
    end
    chk("R2 full at 32", rx_full, 1);
    op(1, 8'hEE, 0, 0, 0, 0, 0);
    chk("R2 full after drop", rx_full, 1);

    // R5, R11
    op(0, 0, 1, 0, 0, 0, 0);
    chk("R5 pop clears full", rx_full, 0);
    chk("R4 rx irq kept at 31", irq_raw[0], 1);
    op(1, 8'h77, 1, 0, 0, 0, 0);
    chk("R11 push+pop keeps not full", rx_full, 0);
    chk("R11 push+pop keeps not empty", rx_empty, 0);
    for (int i = 0; i < 15; i++) op(0, 0, 1, 0, 0, 0, 0);
    chk("R4 rx irq kept at 16", irq_raw[0], 1);
    op(0, 0, 1, 0, 0, 0, 0);
    chk("R4 rx irq cleared at 15", irq_raw[0], 0);
    for (int i = 0; i < 15; i++) op(0, 0, 1, 0, 0, 0, 0);
    chk("R3 rx_empty after drain", rx_empty, 1);
    chk("R3 timeout cleared on empty", irq_raw[2], 0);
    op(0, 0, 1, 0, 0, 0, 0);
    chk("R5 empty pop keeps empty", rx_empty, 1);
    chk("R5 empty pop keeps raw", irq_raw, 3'b010);

    // R9 timeout clear
    op(1, 8'h31, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 1);
    chk("R9 clear drops timeout", irq_raw[2], 0);
    chk("R9 clear leaves data", rx_empty, 0);
    op(1, 8'h32, 0, 0, 0, 0, 1);
    chk("R9 push beats clear", irq_raw[2], 1);
    chk("R2 order after clear", rx_data_out, 8'h31);

    // R10 masking, raw = {1,1,0}
    chk("R10 raw state", irq_raw, 3'b110);
    for (int m = 0; m < 8; m++) begin
      irq_mask = 3'(m);
      #1;
      chk($sformatf("R10 masked m=%0d", m), irq_masked, 3'(m) & 3'b110);
      chk($sformatf("R10 irq m=%0d", m), irq, int'((3'(m) & 3'b110) != 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule